// File: doc/BRIEF.md
# Programmable-Period PWM Timer

This block is a 16-bit timer/counter that produces pulse-width-modulated waveforms on several channels. An external prescaler supplies a clock-enable tick. The counter moves only on cycles where that tick is high and the run bit is set. The period end (TOP) comes from one of four sources: two fixed values, the first compare channel, or a dedicated period register. Two counting shapes are available. Single-slope mode counts up and wraps to zero. Dual-slope mode counts up to TOP and then back down to zero.

All configuration goes through one write port. Select 0 writes the control word, select 1 writes the period register, and select 2+c writes compare channel c. Each channel keeps a pending compare value and an active one. A pending value moves into the active register on a TOP event. The period register has no such buffer and is used as soon as it is written. If it is written below the present count, the counter climbs to 0xFFFF and wraps before it can reach the new TOP. Each channel has a two-bit output mode that chooses between disconnected, non-inverted and inverted waveforms. The overflow, compare-match and period-register-match outputs are single-cycle pulses, registered one cycle after the tick that causes them.

Control word layout: bit 0 selects the shape (0 single-slope, 1 dual-slope). Bits 2:1 select the TOP source (00 fixed 0x00FF, 01 fixed 0x01FF, 10 compare channel 0, 11 period register). Bit 3 is run. Bits 4+2c+1:4+2c hold the output mode of channel c.

Top module: `pwm_timer`

## Requirements
- R1: After reset, cnt_o is 0 and wave_o, match_o, ovf_o and topreg_hit_o are all 0.
- R2: cnt_o changes only after a clock edge at which tick_i is 1 and the run bit (control bit 3) is 1. Otherwise it holds.
- R3: In single-slope mode the count runs 0,1,…,TOP and then returns to 0. ovf_o is high for one cycle in the cycle after the tick on which the count equalled TOP.
- R4: TOP source field (control bits 2:1): 00 gives TOP 0x00FF, 01 gives 0x01FF, 10 gives the active value of compare channel 0, and 11 gives the period register.
- R5: With TOP from compare channel 0, a write to that channel takes effect only at the next TOP event, so the running period always ends at the old TOP. match_o[0] pulses in the same cycle as ovf_o.
- R6: With TOP from the period register, a write takes effect at once. If the new value is below the present count, no overflow occurs until the count has passed 0xFFFF, wrapped to 0 and reached the new TOP. In single-slope mode topreg_hit_o pulses together with ovf_o.
- R7: While a fixed TOP is selected, a value written to a compare channel is ANDed with that TOP before it is stored.
- R8: Single-slope output modes: 00 and 01 drive the output to 0. 10 sets the output at TOP and clears it on a compare match. 11 clears the output at TOP and sets it on a match.
- R9: In dual-slope mode the count goes up from 0 to TOP and down to 0 again. ovf_o pulses in the cycle after the tick taken at 0 while counting down.
- R10: Dual-slope output modes: 10 clears the output on a match while counting up and sets it on a match while counting down. 11 does the opposite.
- R11: When a channel's active compare value equals TOP, its match does not change the output. Only the TOP action applies: mode 10 sets the output and mode 11 clears it.
- R12: match_o[c] pulses in the cycle after a tick on which the count equalled channel c's active compare value. Channel c's active compare value is loaded from its pending value at each TOP event (at TOP, while counting up in dual-slope mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 control, 1 period register, 2+c compare channel c |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Present count |
| wave_o | output | 3 | Per-channel waveform outputs |
| match_o | output | 3 | Per-channel compare-match pulses |
| ovf_o | output | 1 | Overflow pulse |
| topreg_hit_o | output | 1 | Period-register TOP match pulse |

## Verification
The waveform logic is run under several stimulus patterns, and every sampled cycle is compared with a rule that the bench derives from the count and the count's direction.

- Single-slope runs use three channels at the same time: one non-inverted, one inverted and one disconnected. These runs show whether set and clear are swapped and whether the disconnect gating works.
- A dual-slope run uses compare values placed mid-ramp. The bench works out the direction from consecutive counts, so an error in the up/down handling shows up as a wrong output one step from the match.
- Compare values equal to TOP, in both shapes, check the special case. If the match were not suppressed, the dual-slope output would stay low.
- Writes to compare channel 0 and to the period register in the middle of a period show the difference between buffered and unbuffered TOP. The buffered write leaves the current period length unchanged. The unbuffered write, when set below the count, forces a full 16-bit wrap.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the PWM timer.
// Assumes: the control word fields are decoded in pwm_timer.
package pwm_timer_pkg;

    // TOP source field encodings
    typedef enum logic [1:0] {
        TOP_FIX8 = 2'b00,
        TOP_FIX9 = 2'b01,
        TOP_CMPA = 2'b10,
        TOP_REG  = 2'b11
    } top_src_e;

    // Fixed write selects; compare channel c uses SEL_CMP0 + c
    localparam int SEL_CTRL = 0;
    localparam int SEL_TOP  = 1;
    localparam int SEL_CMP0 = 2;

    // Control word bit positions
    localparam int CTL_PC    = 0;
    localparam int CTL_SRC_L = 1;
    localparam int CTL_RUN   = 3;
    localparam int CTL_COM_L = 4;

endpackage

// File: rtl/pwm_cnt.sv
`timescale 1ns/1ps
// Module: pwm_cnt
// The counter core. In single-slope mode it wraps at TOP. In dual-slope
// mode it turns around at TOP and at zero. It reports the TOP event (the
// point where buffers load) and the overflow event, both combinationally.
// Assumes: step_i already includes the run bit. Only equality with TOP is
// detected, so a count above TOP runs on to the full-width wrap.
module pwm_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          pc_i,
    input  logic [CW-1:0] top_i,
    output logic [CW-1:0] cnt_o,
    output logic          up_o,
    output logic          upd_o,
    output logic          ovf_evt_o
);

    logic [CW-1:0] cnt_q;
    logic          up_q;
    logic          at_top;
    logic          at_bot;

    // Decode end points of the count
    always_comb begin
        at_top = (cnt_q == top_i);
        at_bot = (cnt_q == '0);
    end

    // TOP event: at TOP in single-slope mode, or at TOP while counting up in dual-slope mode
    assign upd_o     = step_i & at_top & (up_q | ~pc_i);
    // Overflow: at TOP in single-slope mode, at zero while counting down in dual-slope mode
    assign ovf_evt_o = step_i & (pc_i ? (~up_q & at_bot) : at_top);

    // Advance the count and the direction on each enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (step_i) begin
            if (!pc_i) begin
                up_q  <= 1'b1;
                cnt_q <= at_top ? '0 : cnt_q + 1'b1;
            end else if (up_q) begin
                if (at_top) begin
                    up_q  <= 1'b0;
                    cnt_q <= at_bot ? cnt_q : cnt_q - 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                if (at_bot) begin
                    up_q  <= 1'b1;
                    cnt_q <= at_top ? cnt_q : cnt_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign up_o  = up_q;

endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
// Module: pwm_chan
// One compare channel. It holds a pending and an active compare value,
// registers the match pulse, and drives the waveform according to the
// output mode and the counting shape.
// Assumes: wr_i carries data that has already been masked. upd_i is the
// counter's TOP event.
module pwm_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          pc_i,
    input  logic          up_i,
    input  logic          upd_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] top_i,
    input  logic [1:0]    com_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] act_o,
    output logic          match_o,
    output logic          wave_o
);

    logic [CW-1:0] pend_q;
    logic [CW-1:0] act_q;
    logic          hit;
    logic          st_q;
    logic          mt_q;

    assign hit = step_i & (cnt_i == act_q);

    // Hold the pending compare value written by software
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= '0;
        else if (wr_i) pend_q <= wdata_i;
    end

    // Move the pending value into the active register at the TOP event
    always_ff @(posedge clk) begin
        if (!rst_n)     act_q <= '0;
        else if (upd_i) act_q <= pend_q;
    end

    // Register the match pulse
    always_ff @(posedge clk) begin
        if (!rst_n) mt_q <= 1'b0;
        else        mt_q <= hit;
    end

    // Waveform state: the TOP action comes first, and a match at a compare value equal to TOP is ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= 1'b0;
        end else if (upd_i && (!pc_i || act_q == top_i)) begin
            st_q <= ~com_i[0];
        end else if (hit && act_q != top_i) begin
            st_q <= (pc_i && !up_i) ? ~com_i[0] : com_i[0];
        end
    end

    assign act_o   = act_q;
    assign match_o = mt_q;
    assign wave_o  = com_i[1] & st_q;

endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
// Module: pwm_timer
// The top level. It decodes the write port into the control word, the
// period register and the compare channels, selects TOP, and registers the
// overflow and period-register match pulses.
// Assumes: NCH <= 6, so the control word fits in CW bits.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int            NCH    = 3,
    parameter int            CW     = 16,
    parameter logic [CW-1:0] FIX_LO = 16'h00FF,
    parameter logic [CW-1:0] FIX_HI = 16'h01FF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(NCH+2)-1:0] wr_sel_i,
    input  logic [CW-1:0]            wr_data_i,
    output logic [CW-1:0]            cnt_o,
    output logic [NCH-1:0]           wave_o,
    output logic [NCH-1:0]           match_o,
    output logic                     ovf_o,
    output logic                     topreg_hit_o
);

    localparam int SELW  = $clog2(NCH+2);
    localparam int CTRLW = CTL_COM_L + 2*NCH;

    logic [CTRLW-1:0] ctl_q;
    logic [CW-1:0]    topreg_q;
    logic             ctl_pc;
    logic             ctl_run;
    top_src_e         ctl_src;
    logic [2*NCH-1:0] ctl_com;
    logic [CW-1:0]    top_val;
    logic [CW-1:0]    wmask;
    logic             step;
    logic             up;
    logic             upd;
    logic             ovf_evt;
    logic             ovf_q;
    logic             trh_q;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    act_w [NCH];

    assign ctl_pc  = ctl_q[CTL_PC];
    assign ctl_run = ctl_q[CTL_RUN];
    assign ctl_src = top_src_e'(ctl_q[CTL_SRC_L+1:CTL_SRC_L]);
    assign ctl_com = ctl_q[CTRLW-1:CTL_COM_L];
    assign step    = tick_i & ctl_run;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)                                      ctl_q <= '0;
        else if (wr_en_i && wr_sel_i == SELW'(SEL_CTRL)) ctl_q <= wr_data_i[CTRLW-1:0];
    end

    // Period register, used as TOP without buffering
    always_ff @(posedge clk) begin
        if (!rst_n)                                     topreg_q <= '0;
        else if (wr_en_i && wr_sel_i == SELW'(SEL_TOP)) topreg_q <= wr_data_i;
    end

    // Select TOP from the source field
    always_comb begin
        unique case (ctl_src)
            TOP_FIX8: top_val = FIX_LO;
            TOP_FIX9: top_val = FIX_HI;
            TOP_CMPA: top_val = act_w[0];
            default:  top_val = topreg_q;
        endcase
    end

    // Compare writes keep only the bits a fixed TOP can reach
    assign wmask = ctl_src[1] ? '1 : top_val;

    pwm_cnt #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .pc_i      (ctl_pc),
        .top_i     (top_val),
        .cnt_o     (cnt),
        .up_o      (up),
        .upd_o     (upd),
        .ovf_evt_o (ovf_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_i  (step),
            .pc_i    (ctl_pc),
            .up_i    (up),
            .upd_i   (upd),
            .cnt_i   (cnt),
            .top_i   (top_val),
            .com_i   (ctl_com[2*c+1:2*c]),
            .wr_i    (wr_en_i && wr_sel_i == SELW'(SEL_CMP0 + c)),
            .wdata_i (wr_data_i & wmask),
            .act_o   (act_w[c]),
            .match_o (match_o[c]),
            .wave_o  (wave_o[c])
        );
    end

    // Register the overflow pulse and the period-register match pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            trh_q <= 1'b0;
        end else begin
            ovf_q <= ovf_evt;
            trh_q <= step && ctl_src == TOP_REG && cnt == topreg_q;
        end
    end

    assign cnt_o        = cnt;
    assign ovf_o        = ovf_q;
    assign topreg_hit_o = trh_q;

endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
// Module: pwm_timer_chk
// Property checker, bound into pwm_timer. It watches the ports together
// with the decoded control state.
// Assumes: it is attached through the bind statement at the end of this file.
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic [CW-1:0]    cnt_o,
    input logic [NCH-1:0]   wave_o,
    input logic [NCH-1:0]   match_o,
    input logic             ovf_o,
    input logic             topreg_hit_o,
    input logic             run_i,
    input logic             pc_i,
    input top_src_e         src_i,
    input logic [CW-1:0]    top_i,
    input logic [2*NCH-1:0] com_i
);

    // R2: without an enabled tick the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && run_i) |=> $stable(cnt_o));

    // R2: a single-slope tick below or above TOP moves the count by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !pc_i && cnt_o != top_i) |=> cnt_o == CW'($past(cnt_o) + 1'b1));

    // R3: a single-slope tick at TOP wraps to zero and flags overflow
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !pc_i && cnt_o == top_i) |=> (cnt_o == '0 && ovf_o));

    // R5: with TOP from channel 0, its match coincides with the overflow
    p_cmpa_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !pc_i && src_i == TOP_CMPA && cnt_o == top_i) |=> (ovf_o && match_o[0]));

    // R6: with TOP from the period register, its match coincides with the overflow
    p_reg_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !pc_i && src_i == TOP_REG && cnt_o == top_i) |=> (ovf_o && topreg_hit_o));

    // R9: in dual-slope mode an overflow follows a tick taken at zero
    p_pc_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_i && $past(pc_i) && ovf_o) |-> $past(cnt_o) == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R8: a disconnected output mode keeps the waveform low
        p_disc_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !com_i[2*c+1] |-> !wave_o[c]);
    end

endmodule

bind pwm_timer pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .cnt_o        (cnt_o),
    .wave_o       (wave_o),
    .match_o      (match_o),
    .ovf_o        (ovf_o),
    .topreg_hit_o (topreg_hit_o),
    .run_i        (ctl_run),
    .pc_i         (ctl_pc),
    .src_i        (ctl_src),
    .top_i        (top_val),
    .com_i        (ctl_com)
);

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each. Inputs are driven and outputs
// sampled at the falling clock edge.
module sim_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] cnt_o;
    logic [2:0]  wave_o;
    logic [2:0]  match_o;
    logic        ovf_o;
    logic        topreg_hit_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .cnt_o        (cnt_o),
        .wave_o       (wave_o),
        .match_o      (match_o),
        .ovf_o        (ovf_o),
        .topreg_hit_o (topreg_hit_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ctl(input bit pc, input logic [1:0] src, input bit run,
                                        input logic [1:0] m0, input logic [1:0] m1, input logic [1:0] m2);
        return {6'b0, m2, m1, m0, run, src, pc};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_i = 1'b1;
        wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int sel, input logic [15:0] d);
        wr_en_i = 1'b1;
        wr_sel_i = 3'(sel);
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_ovf(input int k);
        int seen = 0;
        for (int g = 0; g < 150000 && seen < k; g++) begin
            @(negedge clk);
            if (ovf_o) seen++;
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(cnt_o == 0, "R1 count", cnt_o, 0);
        chk(wave_o == 0 && match_o == 0, "R1 wave/match", {wave_o, match_o}, 0);
        chk(!ovf_o && !topreg_hit_o, "R1 flags", {ovf_o, topreg_hit_o}, 0);
        wr(0, ctl(0, 2'b00, 0, 2'b10, 2'b10, 2'b10));
        repeat (10) @(negedge clk);
        chk(cnt_o == 0, "R2 stopped holds", cnt_o, 0);
    endtask

    task automatic t_tick();
        do_reset();
        tick_i = 1'b0;
        wr(0, ctl(0, 2'b00, 1, 2'b00, 2'b00, 2'b00));
        repeat (5) @(negedge clk);
        chk(cnt_o == 0, "R2 no tick", cnt_o, 0);
        for (int i = 1; i <= 3; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            chk(cnt_o == 16'(i), "R2 one tick", cnt_o, i);
            repeat (3) @(negedge clk);
            chk(cnt_o == 16'(i), "R2 idle", cnt_o, i);
        end
        tick_i = 1'b1;
    endtask

    task automatic t_fast();
        logic [15:0] prv, cur, mx;
        do_reset();
        wr(0, ctl(0, 2'b00, 0, 2'b10, 2'b11, 2'b00));
        wr(2, 16'h0040);
        wr(3, 16'h0080);
        wr(4, 16'h0010);
        wr(0, ctl(0, 2'b00, 1, 2'b10, 2'b11, 2'b00));
        wait_ovf(2);
        prv = cnt_o;
        mx = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            cur = cnt_o;
            if (cur > mx) mx = cur;
            chk(ovf_o == (prv == 16'hFF), "R3 ovf", ovf_o, prv == 16'hFF);
            chk(wave_o[0] == (cur <= 16'h40), "R8 mode10", wave_o[0], cur <= 16'h40);
            chk(wave_o[1] == (cur > 16'h80), "R8 mode11", wave_o[1], cur > 16'h80);
            chk(wave_o[2] == 1'b0, "R8 mode00", wave_o[2], 0);
            chk(match_o[0] == (prv == 16'h40), "R12 match0", match_o[0], prv == 16'h40);
            chk(match_o[1] == (prv == 16'h80), "R12 match1", match_o[1], prv == 16'h80);
            chk(match_o[2] == (prv == 16'h10), "R12 match2", match_o[2], prv == 16'h10);
            prv = cur;
        end
        chk(mx == 16'hFF, "R4 fixed 0xFF", mx, 16'hFF);
    endtask

    task automatic t_fix9();
        logic [15:0] prv, mx;
        do_reset();
        wr(0, ctl(0, 2'b01, 1, 2'b01, 2'b00, 2'b00));
        wait_ovf(1);
        prv = cnt_o;
        mx = 0;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            if (cnt_o > mx) mx = cnt_o;
            chk(ovf_o == (prv == 16'h1FF), "R4 ovf at 0x1FF", ovf_o, prv == 16'h1FF);
            chk(wave_o[0] == 1'b0, "R8 mode01", wave_o[0], 0);
            prv = cnt_o;
        end
        chk(mx == 16'h1FF, "R4 fixed 0x1FF", mx, 16'h1FF);
    endtask

    task automatic t_mask();
        logic [15:0] prv;
        do_reset();
        wr(0, ctl(0, 2'b00, 0, 2'b00, 2'b10, 2'b00));
        wr(3, 16'h0130);
        wr(0, ctl(0, 2'b00, 1, 2'b00, 2'b10, 2'b00));
        wait_ovf(2);
        prv = cnt_o;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk(wave_o[1] == (cnt_o <= 16'h30), "R7 masked compare", wave_o[1], cnt_o <= 16'h30);
            chk(match_o[1] == (prv == 16'h30), "R7 masked match", match_o[1], prv == 16'h30);
            prv = cnt_o;
        end
    endtask

    task automatic t_cmpa();
        logic [15:0] prv, mx;
        do_reset();
        wr(0, ctl(0, 2'b10, 0, 2'b00, 2'b10, 2'b00));
        wr(2, 16'd20);
        wr(3, 16'd5);
        wr(0, ctl(0, 2'b10, 1, 2'b00, 2'b10, 2'b00));
        wait_ovf(2);
        prv = cnt_o;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            chk(ovf_o == (prv == 16'd20), "R5 period 20", ovf_o, prv == 16'd20);
            chk(match_o[0] == ovf_o, "R5 match with ovf", match_o[0], ovf_o);
            chk(wave_o[1] == (cnt_o <= 16'd5), "R8 wave under A top", wave_o[1], cnt_o <= 16'd5);
            prv = cnt_o;
        end
        for (int g = 0; g < 100 && cnt_o != 16'd5; g++) @(negedge clk);
        wr(2, 16'd10);
        mx = cnt_o;
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (ovf_o) break;
            if (cnt_o > mx) mx = cnt_o;
        end
        chk(mx == 16'd20, "R5 old TOP kept", mx, 20);
        mx = 0;
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (ovf_o) break;
            if (cnt_o > mx) mx = cnt_o;
        end
        chk(mx == 16'd10, "R5 new TOP after update", mx, 10);
    endtask

    task automatic t_topreg();
        logic [15:0] prv, mx;
        bit wrapped;
        do_reset();
        wr(1, 16'd200);
        wr(0, ctl(0, 2'b11, 1, 2'b00, 2'b00, 2'b00));
        wait_ovf(1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            chk(topreg_hit_o == ovf_o, "R6 hit with ovf", topreg_hit_o, ovf_o);
        end
        for (int g = 0; g < 400 && cnt_o != 16'd150; g++) @(negedge clk);
        wr(1, 16'd100);
        wrapped = 0;
        prv = cnt_o;
        for (int g = 0; g < 70000; g++) begin
            @(negedge clk);
            if (prv == 16'hFFFF && cnt_o == 0) wrapped = 1;
            if (ovf_o) break;
            prv = cnt_o;
        end
        chk(wrapped, "R6 missed TOP wraps", wrapped, 1);
        chk(prv == 16'd100, "R6 ovf at new TOP", prv, 100);
        chk(topreg_hit_o, "R6 hit flag", topreg_hit_o, 1);
        for (int g = 0; g < 200 && cnt_o != 16'd20; g++) @(negedge clk);
        wr(1, 16'd50);
        mx = cnt_o;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            if (ovf_o) break;
            if (cnt_o > mx) mx = cnt_o;
        end
        chk(mx == 16'd50, "R6 immediate TOP", mx, 50);
    endtask

    task automatic t_phase();
        logic [15:0] prv, cur, mx;
        bit up;
        do_reset();
        wr(0, ctl(1, 2'b00, 0, 2'b10, 2'b11, 2'b10));
        wr(2, 16'h0040);
        wr(3, 16'h0080);
        wr(4, 16'h00FF);
        wr(0, ctl(1, 2'b00, 1, 2'b10, 2'b11, 2'b10));
        wait_ovf(2);
        prv = cnt_o;
        mx = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            cur = cnt_o;
            up = cur > prv;
            if (cur > mx) mx = cur;
            chk(ovf_o == (prv == 0 && cur == 1), "R9 ovf at bottom", ovf_o, prv == 0 && cur == 1);
            chk(cur == prv + 16'd1 || cur + 16'd1 == prv, "R9 step of one", cur, prv);
            chk(wave_o[0] == (up ? cur <= 16'h40 : cur < 16'h40), "R10 mode10", wave_o[0],
                up ? cur <= 16'h40 : cur < 16'h40);
            chk(wave_o[1] == (up ? cur > 16'h80 : cur >= 16'h80), "R10 mode11", wave_o[1],
                up ? cur > 16'h80 : cur >= 16'h80);
            chk(wave_o[2] == 1'b1, "R11 compare at TOP dual", wave_o[2], 1);
            chk(match_o[0] == (prv == 16'h40), "R12 dual match", match_o[0], prv == 16'h40);
            prv = cur;
        end
        chk(mx == 16'hFF, "R9 peak", mx, 16'hFF);
    endtask

    task automatic t_special();
        logic [15:0] prv;
        do_reset();
        wr(0, ctl(0, 2'b00, 0, 2'b10, 2'b11, 2'b00));
        wr(2, 16'h00FF);
        wr(3, 16'h00FF);
        wr(0, ctl(0, 2'b00, 1, 2'b10, 2'b11, 2'b00));
        wait_ovf(2);
        prv = cnt_o;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk(wave_o[0] == 1'b1, "R11 mode10 at TOP", wave_o[0], 1);
            chk(wave_o[1] == 1'b0, "R11 mode11 at TOP", wave_o[1], 0);
            chk(match_o[0] == (prv == 16'hFF), "R11 match still flagged", match_o[0], prv == 16'hFF);
            prv = cnt_o;
        end
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_tick();
        t_fast();
        t_fix9();
        t_mask();
        t_cmpa();
        t_topreg();
        t_phase();
        t_special();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule